// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM interface. After reset it runs the mandatory start-up sequence, one clock at a time. It holds the clock-enable low while the supply and clock settle, then raises it. It issues the precharge, mode-register, refresh and driver-calibration commands in the order the device needs, and it keeps the required spacing between them. Every wait is a parameter given in controller clock cycles, so the same logic serves any clock frequency once the parameters are scaled. While a wait runs, the command pins carry NOP.

The operating values for the four mode registers come in on input buses and must stay stable during initialization. The sequencer forces only the bits that the start-up procedure fixes: the DLL enable and reset bits, the high address bit, the bank select and the calibration field. All other bits pass through unchanged. When the last calibration command has been followed by its mode-register gap, `init_done` rises and stays high until the next reset. From then on the pins rest at NOP with the clock-enable high, and the normal command scheduler takes over the interface.

Top module: `ddr2_init_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in the power-on state. In that state the clock-enable is low, ODT is low, the command is NOP ({cs_n,ras_n,cas_n,we_n}=0111), `init_done` is low and bank and address are zero. The state lasts STABLE_CYC cycles after reset is released, counted from cycle 0.
- R2: The clock-enable rises in cycle STABLE_CYC and then never falls before a reset. It is followed by CKE_WAIT_CYC cycles of NOP, and then a precharge-all in cycle STABLE_CYC+CKE_WAIT_CYC. Precharge-all is command 0010 with A10=1, all other address bits 0 and bank 00.
- R3: The command codes are NOP 0111, precharge 0010, auto-refresh 0001 and mode-register set 0000. No command other than those listed in R2 and R4 to R10 is ever issued.
- R4: After the first precharge-all come two mode-register writes. The first uses bank 10 with address = `emr2_ops`. The second uses bank 11 with address = `emr3_ops`.
- R5: Next comes a write to bank 01 with address = `emr1_ops`, except that A0, A7, A8, A9 and A13 are forced to 0. This enables the DLL.
- R6: Next comes a write to bank 00 with address = `mr_ops`, except that A8 is forced to 1 and A13 to 0. This resets the DLL, and it is issued exactly once per sequence.
- R7: The distance from one command to the next is T_MRD cycles after a mode-register write, T_RP cycles after a precharge-all and T_RFC cycles after an auto-refresh.
- R8: After the DLL reset come a second precharge-all, then REFRESH_CNT auto-refresh commands (address 0, bank 0), then a write to bank 00 with address = `mr_ops` with A8 and A13 forced to 0.
- R9: The calibration-default write is issued no earlier than DLL_GAP cycles after the DLL-reset write. If the schedule would reach it sooner, it is delayed to exactly that cycle.
- R10: The calibration-default write goes to bank 01 with the R5 address but A9:A7=111. The calibration-exit write follows it, to bank 01 with the R5 address (A9:A7=000).
- R11: `init_done` rises T_MRD cycles after the calibration-exit write and stays high until reset. While it is high, the clock-enable is high and the command is NOP.
- R12: ODT stays low in every cycle.
- R13: A reset asserted in the middle of the sequence returns the block to the R1 state, and the whole sequence then runs again with its timing counted from the new reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| emr1_ops | input | 14 | Operating bits for extended mode register 1 |
| emr2_ops | input | 14 | Operating bits for extended mode register 2 |
| emr3_ops | input | 14 | Operating bits for extended mode register 3 |
| mr_ops | input | 14 | Operating bits for the main mode register |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| odt | output | 1 | On-die termination enable |
| ba | output | 2 | Bank address |
| addr | output | 14 | Address bus |
| init_done | output | 1 | Sequence finished, interface free |

## Verification
A scoreboard checks each command against the cycle it should land in and its bank and address values. Three operating-value patterns are used.
- All-ones operating values show that the forced bits really are cleared or set.
- A sparse pattern with the forced positions already zero shows that the remaining bits pass through.
- An alternating pattern tells the four mode-register targets apart by their bank codes.

The bench parameters make the DLL gap longer than the refresh schedule, so a design that ignores the gap issues the calibration command too early. A reset in the middle of a run, followed by a full rerun, shows that the timing restarts from the new reset release.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [3:0] {
        ST_POWER,
        ST_CKE_UP,
        ST_PREA_FIRST,
        ST_EMR2,
        ST_EMR3,
        ST_EMR1_DLL,
        ST_MR_DLL_RST,
        ST_PREA_SECOND,
        ST_REFRESH,
        ST_MR_OPS,
        ST_OCD_DEFAULT,
        ST_OCD_EXIT,
        ST_READY
    } init_step_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_MRS = 4'b0000;

    localparam int BIT_DLL_OFF  = 0;
    localparam int BIT_OCD_LO   = 7;
    localparam int BIT_DLL_RST  = 8;
    localparam int BIT_OCD_HI   = 9;
    localparam int BIT_PRE_ALL  = 10;
    localparam int BIT_TOP      = 13;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    localparam logic [W-1:0] CNT_RST = W'(RST_VAL);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_RST;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    // a new wait may only start once the previous one has run out
    AST_TIMER_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
        load |-> (cnt_q == '0)); // R7

endmodule

// File: rtl/ddr2_init_dll_gap.sv
module ddr2_init_dll_gap #(
    parameter int GAP = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic dll_rst_fire,
    input  logic ocd_fire,
    output logic gap_met
);
    localparam int CW = $clog2(GAP + 1);
    localparam logic [CW-1:0] CNT_SAT = CW'(GAP);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } gap_state_t;

    gap_state_t gs_d, gs_q;

    always_comb begin
        gs_d = gs_q;
        if (dll_rst_fire) begin
            gs_d.run = 1'b1;
            gs_d.cnt = CW'(1);
        end else if (gs_q.run && gs_q.cnt != CNT_SAT) begin
            gs_d.cnt = gs_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gs_q <= '0;
        end else begin
            gs_q <= gs_d;
        end
    end

    assign gap_met = gs_q.run && (gs_q.cnt >= CNT_SAT);

    AST_OCD_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
        ocd_fire |-> (gs_q.run && gs_q.cnt >= CNT_SAT)); // R9

    AST_DLL_RST_ONCE: assert property (@(posedge clk) disable iff (rst)
        dll_rst_fire |-> !gs_q.run); // R6

endmodule

// File: rtl/ddr2_init_cmd_enc.sv
module ddr2_init_cmd_enc
    import ddr2_init_pkg::*;
#(
    parameter int AW = 14
) (
    input  init_step_e     step,
    input  logic           fire,
    input  logic [AW-1:0]  emr1_ops,
    input  logic [AW-1:0]  emr2_ops,
    input  logic [AW-1:0]  emr3_ops,
    input  logic [AW-1:0]  mr_ops,
    output logic [3:0]     cmd,
    output logic [1:0]     ba,
    output logic [AW-1:0]  addr,
    output logic           cke,
    output logic           odt
);
    logic [AW-1:0] emr1_base;
    logic [AW-1:0] mr_base;

    always_comb begin
        emr1_base = emr1_ops;
        emr1_base[BIT_DLL_OFF] = 1'b0;
        emr1_base[BIT_TOP]     = 1'b0;
        emr1_base[BIT_OCD_HI:BIT_OCD_LO] = '0;
        mr_base = mr_ops;
        mr_base[BIT_TOP]     = 1'b0;
        mr_base[BIT_DLL_RST] = 1'b0;
    end

    always_comb begin
        cmd  = CMD_NOP;
        ba   = 2'b00;
        addr = '0;
        cke  = (step != ST_POWER);
        odt  = 1'b0;
        if (fire) begin
            unique case (step)
                ST_PREA_FIRST, ST_PREA_SECOND: begin
                    cmd = CMD_PRE;
                    addr[BIT_PRE_ALL] = 1'b1;
                end
                ST_EMR2: begin
                    cmd  = CMD_MRS;
                    ba   = 2'b10;
                    addr = emr2_ops;
                end
                ST_EMR3: begin
                    cmd  = CMD_MRS;
                    ba   = 2'b11;
                    addr = emr3_ops;
                end
                ST_EMR1_DLL, ST_OCD_EXIT: begin
                    cmd  = CMD_MRS;
                    ba   = 2'b01;
                    addr = emr1_base;
                end
                ST_OCD_DEFAULT: begin
                    cmd  = CMD_MRS;
                    ba   = 2'b01;
                    addr = emr1_base;
                    addr[BIT_OCD_HI:BIT_OCD_LO] = '1;
                end
                ST_MR_DLL_RST: begin
                    cmd  = CMD_MRS;
                    addr = mr_base;
                    addr[BIT_DLL_RST] = 1'b1;
                end
                ST_MR_OPS: begin
                    cmd  = CMD_MRS;
                    addr = mr_base;
                end
                ST_REFRESH: begin
                    cmd = CMD_REF;
                end
                default: begin
                    cmd = CMD_NOP;
                end
            endcase
        end
    end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W       = 14,
    parameter int STABLE_CYC   = 20000,
    parameter int CKE_WAIT_CYC = 40,
    parameter int T_MRD        = 2,
    parameter int T_RP         = 3,
    parameter int T_RFC        = 13,
    parameter int REFRESH_CNT  = 2,
    parameter int DLL_GAP      = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] emr1_ops,
    input  logic [ADDR_W-1:0] emr2_ops,
    input  logic [ADDR_W-1:0] emr3_ops,
    input  logic [ADDR_W-1:0] mr_ops,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cke,
    output logic              odt,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int TMAX = max_of(max_of(STABLE_CYC, CKE_WAIT_CYC),
                                 max_of(T_MRD, max_of(T_RP, T_RFC)));
    localparam int TW = $clog2(TMAX + 1);
    localparam int RW = max_of(1, $clog2(REFRESH_CNT + 1));

    localparam logic [TW-1:0] LD_CKE = TW'(CKE_WAIT_CYC - 1);
    localparam logic [TW-1:0] LD_MRD = TW'((T_MRD > 1) ? T_MRD - 2 : 0);
    localparam logic [TW-1:0] LD_RP  = TW'((T_RP  > 1) ? T_RP  - 2 : 0);
    localparam logic [TW-1:0] LD_RFC = TW'((T_RFC > 1) ? T_RFC - 2 : 0);
    localparam logic [RW-1:0] REF_LAST = RW'(REFRESH_CNT - 1);

    typedef struct packed {
        init_step_e    step;
        logic          waiting;
        logic [RW-1:0] refs;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;
    logic          dll_gap_met;
    logic          cmd_fire;
    logic          step_is_cmd;
    logic          gap_multi;
    logic [TW-1:0] gap_load;
    init_step_e    step_after;
    logic [RW-1:0] refs_after;
    logic [3:0]    cmd_bus;

    // which steps put a command on the pins, and the spacing that follows it
    always_comb begin
        step_is_cmd = !(st_q.step inside {ST_POWER, ST_CKE_UP, ST_READY});
        unique case (st_q.step)
            ST_PREA_FIRST, ST_PREA_SECOND: begin
                gap_multi = (T_RP > 1);
                gap_load  = LD_RP;
            end
            ST_REFRESH: begin
                gap_multi = (T_RFC > 1);
                gap_load  = LD_RFC;
            end
            default: begin
                gap_multi = (T_MRD > 1);
                gap_load  = LD_MRD;
            end
        endcase
        cmd_fire = step_is_cmd && !st_q.waiting &&
                   ((st_q.step != ST_OCD_DEFAULT) || dll_gap_met);
    end

    // successor of each command step
    always_comb begin
        refs_after = st_q.refs;
        unique case (st_q.step)
            ST_PREA_FIRST:  step_after = ST_EMR2;
            ST_EMR2:        step_after = ST_EMR3;
            ST_EMR3:        step_after = ST_EMR1_DLL;
            ST_EMR1_DLL:    step_after = ST_MR_DLL_RST;
            ST_MR_DLL_RST:  step_after = ST_PREA_SECOND;
            ST_PREA_SECOND: step_after = ST_REFRESH;
            ST_REFRESH: begin
                if (st_q.refs == REF_LAST) begin
                    step_after = ST_MR_OPS;
                    refs_after = '0;
                end else begin
                    step_after = ST_REFRESH;
                    refs_after = st_q.refs + 1'b1;
                end
            end
            ST_MR_OPS:      step_after = ST_OCD_DEFAULT;
            ST_OCD_DEFAULT: step_after = ST_OCD_EXIT;
            ST_OCD_EXIT:    step_after = ST_READY;
            default:        step_after = st_q.step;
        endcase
    end

    // next-state computation
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q.step)
            ST_POWER: begin
                if (tmr_expired) begin
                    st_d.step = ST_CKE_UP;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_CKE;
                end
            end
            ST_CKE_UP: begin
                if (tmr_expired) begin
                    st_d.step = ST_PREA_FIRST;
                end
            end
            ST_READY: begin
                st_d = st_q;
            end
            default: begin
                if (cmd_fire) begin
                    if (gap_multi) begin
                        st_d.waiting = 1'b1;
                        tmr_load     = 1'b1;
                        tmr_val      = gap_load;
                    end else begin
                        st_d.step = step_after;
                        st_d.refs = refs_after;
                    end
                end else if (st_q.waiting && tmr_expired) begin
                    st_d.waiting = 1'b0;
                    st_d.step    = step_after;
                    st_d.refs    = refs_after;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{step: ST_POWER, waiting: 1'b0, refs: '0};
        end else begin
            st_q <= st_d;
        end
    end

    ddr2_init_timer #(
        .W       (TW),
        .RST_VAL (STABLE_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    ddr2_init_dll_gap #(
        .GAP (DLL_GAP)
    ) u_dll_gap (
        .clk          (clk),
        .rst          (rst),
        .dll_rst_fire (cmd_fire && st_q.step == ST_MR_DLL_RST),
        .ocd_fire     (cmd_fire && st_q.step == ST_OCD_DEFAULT),
        .gap_met      (dll_gap_met)
    );

    ddr2_init_cmd_enc #(
        .AW (ADDR_W)
    ) u_enc (
        .step     (st_q.step),
        .fire     (cmd_fire),
        .emr1_ops (emr1_ops),
        .emr2_ops (emr2_ops),
        .emr3_ops (emr3_ops),
        .mr_ops   (mr_ops),
        .cmd      (cmd_bus),
        .ba       (ba),
        .addr     (addr),
        .cke      (cke),
        .odt      (odt)
    );

    assign {cs_n, ras_n, cas_n, we_n} = cmd_bus;
    assign init_done = (st_q.step == ST_READY);

    AST_POWER_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
        (st_q.step == ST_POWER) |-> (!cke && cmd_bus == CMD_NOP)); // R1

    AST_CKE_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke); // R2

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done); // R11

    AST_READY_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (cke && cmd_bus == CMD_NOP)); // R11

    AST_NO_CMD_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
        st_q.waiting |-> (cmd_bus == CMD_NOP)); // R7

endmodule

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_seq_tb;

    localparam int ST   = 300;
    localparam int CW   = 20;
    localparam int MRD  = 2;
    localparam int RP   = 3;
    localparam int RFC  = 6;
    localparam int NREF = 2;
    localparam int GAP  = 60;

    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] REF = 4'b0001;
    localparam logic [3:0] MRS = 4'b0000;

    typedef struct {
        int          cyc;
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [13:0] addr;
        string       req;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] emr1_ops = '0, emr2_ops = '0, emr3_ops = '0, mr_ops = '0;
    logic        cs_n, ras_n, cas_n, we_n, cke, odt, init_done;
    logic [1:0]  ba;
    logic [13:0] addr;

    exp_item_t exp_q[$];
    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int done_cyc = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    ddr2_init_seq #(
        .ADDR_W(14), .STABLE_CYC(ST), .CKE_WAIT_CYC(CW), .T_MRD(MRD),
        .T_RP(RP), .T_RFC(RFC), .REFRESH_CNT(NREF), .DLL_GAP(GAP)
    ) u_dut (
        .clk(clk), .rst(rst), .emr1_ops(emr1_ops), .emr2_ops(emr2_ops),
        .emr3_ops(emr3_ops), .mr_ops(mr_ops), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .cke(cke), .odt(odt), .ba(ba),
        .addr(addr), .init_done(init_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)",
                     req, what, act, exp, cyc);
        end
    endtask

    task automatic push(input int c, input logic [3:0] cm, input logic [1:0] b,
                        input logic [13:0] a, input string req, input int limit);
        exp_item_t it;
        if (c > limit) return;
        it.cyc = c; it.cmd = cm; it.ba = b; it.addr = a; it.req = req;
        exp_q.push_back(it);
    endtask

    // builds the expected command list from the requirements
    task automatic build_schedule(input int limit);
        int c, t0;
        logic [13:0] e1;
        e1 = emr1_ops & ~14'h2381;
        c = ST + CW;
        push(c, PRE, 2'b00, 14'h0400, "R2", limit); c += RP;
        push(c, MRS, 2'b10, emr2_ops, "R4", limit); c += MRD;
        push(c, MRS, 2'b11, emr3_ops, "R4", limit); c += MRD;
        push(c, MRS, 2'b01, e1, "R5", limit); c += MRD;
        t0 = c;
        push(c, MRS, 2'b00, (mr_ops & ~14'h2000) | 14'h0100, "R6", limit); c += MRD;
        push(c, PRE, 2'b00, 14'h0400, "R8", limit); c += RP;
        for (int i = 0; i < NREF; i++) begin
            push(c, REF, 2'b00, 14'h0000, "R7", limit); c += RFC;
        end
        push(c, MRS, 2'b00, mr_ops & ~14'h2100, "R8", limit); c += MRD;
        if (c < t0 + GAP) c = t0 + GAP;
        push(c, MRS, 2'b01, e1 | 14'h0380, "R9", limit); c += MRD;
        push(c, MRS, 2'b01, e1, "R10", limit); c += MRD;
        done_cyc = c;
    endtask

    // monitor: every non-NOP command is popped and compared
    always @(negedge clk) begin
        if (!rst) begin
            check(odt == 1'b0, "R12", "odt", odt, 0);
            if ({cs_n, ras_n, cas_n, we_n} != NOP) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected command",
                          {cs_n, ras_n, cas_n, we_n}, NOP);
                end else begin
                    exp_item_t it;
                    it = exp_q.pop_front();
                    check(cyc == it.cyc, it.req, "command cycle", cyc, it.cyc);
                    check({cs_n, ras_n, cas_n, we_n} == it.cmd, it.req, "command code",
                          {cs_n, ras_n, cas_n, we_n}, it.cmd);
                    check(ba == it.ba, it.req, "bank", ba, it.ba);
                    check(addr == it.addr, it.req, "address", addr, it.addr);
                end
            end
        end
    end

    task automatic wait_cyc(input int k);
        @(negedge clk);
        while (cyc != k) @(negedge clk);
    endtask

    task automatic release_reset();
        @(posedge clk); #1 rst = 1'b0;
    endtask

    task automatic assert_reset();
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic check_power_state(input string req);
        check(cke == 1'b0, req, "cke in power state", cke, 0);
        check({cs_n, ras_n, cas_n, we_n} == NOP, req, "NOP in power state",
              {cs_n, ras_n, cas_n, we_n}, NOP);
        check(init_done == 1'b0, req, "init_done in power state", init_done, 0);
        check(ba == 2'b00 && addr == '0, req, "bus zero", {ba, addr}, 0);
    endtask

    task automatic full_run(input logic [13:0] e1, input logic [13:0] e2,
                            input logic [13:0] e3, input logic [13:0] m);
        emr1_ops = e1; emr2_ops = e2; emr3_ops = e3; mr_ops = m;
        build_schedule(1 << 30);
        release_reset();
        wait_cyc(0);
        check_power_state("R1");
        wait_cyc(ST - 1);
        check(cke == 1'b0, "R1", "cke before stable time", cke, 0);
        wait_cyc(ST);
        check(cke == 1'b1, "R2", "cke after stable time", cke, 1);
        wait_cyc(done_cyc - 1);
        check(init_done == 1'b0, "R11", "init_done early", init_done, 0);
        wait_cyc(done_cyc);
        check(init_done == 1'b1, "R11", "init_done on time", init_done, 1);
        wait_cyc(done_cyc + 25);
        check(init_done == 1'b1 && cke == 1'b1, "R11", "held ready",
              {init_done, cke}, 3);
        check(exp_q.size() == 0, "R3", "commands left unissued", exp_q.size(), 0);
        exp_q.delete();
        assert_reset();
        check_power_state("R13");
    endtask

    initial begin
        repeat (3) @(posedge clk);

        // run 1: all ones, exposes every forced bit
        full_run(14'h3FFF, 14'h3FFF, 14'h3FFF, 14'h3FFF);
        // run 2: sparse pattern, forced positions already zero
        full_run(14'h0446, 14'h0021, 14'h0002, 14'h0432);

        // run 3: abort right after the EMR3 write, then rerun from scratch (R13)
        emr1_ops = 14'h1555; emr2_ops = 14'h2AAA; emr3_ops = 14'h1234; mr_ops = 14'h0A5A;
        build_schedule(ST + CW + RP + MRD);
        release_reset();
        wait_cyc(ST + CW + RP + MRD);
        assert_reset();
        check_power_state("R13");
        check(exp_q.size() == 0, "R13", "partial commands missing", exp_q.size(), 0);
        exp_q.delete();
        full_run(14'h1555, 14'h2AAA, 14'h1234, 14'h0A5A);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule